// File: doc/BRIEF.md
# Three-Wire Control Bus Slave

This block is the device side of a host-driven serial control bus with three lines: an ident line, a bus clock and a shared open-drain data line. All three lines rest high when the bus is idle. The host pulls ident low to open a transfer and clocks in an 8-bit address, least significant bit first. It then raises ident to close the address phase and clocks 8 or 16 data bits, again least significant bit first. A short low pulse on ident ends the transfer, and that pulse is the moment a written value takes effect.

The slave keeps a bank of 35 coefficient registers, each 8 bits wide. It answers only after the host has written the device's select word into a shared select register, so several slaves of different kinds can share one address range. Read accesses return a coefficient bit by bit on the data line. The slave only ever pulls the data line low. The bus lines are synchronised into the system clock domain. A transfer may stall for any length of time, because no timeout exists.

Top module: `tcb_slave`

## Requirements
- R1: After reset, every coefficient entry is 0x00 except entry 33, which is 0x08. The device is deselected and the data line is released.
- R2: An address phase is exactly 8 bus-clock rising edges while ident is low, captured least significant bit first. An address phase with any other number of edges is discarded, together with the rest of that transfer.
- R3: A write changes the bank only on the ident low pulse that follows the data bits. Before that pulse the bank is unchanged.
- R4: An 8-bit write of 15 to address 102 selects the device, and any other value written there deselects it. The select register accepts writes whether or not the device is selected.
- R5: While the device is selected, an 8-bit write to address 64+i (i from 0 to 34) sets entry i to the byte written.
- R6: A 16-bit write to address 64+i with i < 34 stores the first byte sent in entry i and the second byte in entry i+1. A 16-bit write to the last entry is ignored.
- R7: Writes leave the bank unchanged in each of these cases: the device is deselected, the address lies outside 64..98 (other than 102), or the data bit count is neither 8 nor 16.
- R8: While the device is selected, a read of address 160+i returns entry i. Bit 0 is presented on the data line before the first data clock rises, and each later bit follows one rising edge later. A 0 bit pulls the line low and a 1 bit releases it.
- R9: A read while the device is deselected, or of an address outside 160..194, leaves the line released, so the host reads 0xFF.
- R10: A transfer that stalls for a long time in the middle of its data bits still completes normally.
- R11: The data line is pulled low only during the data phase of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_ident_i | input | 1 | Bus ident line (low during the address phase and the end pulse) |
| bus_clk_i | input | 1 | Bus clock line; data is taken on its rising edge |
| bus_data_i | input | 1 | Level seen on the shared data line |
| bus_data_pull_o | output | 1 | High means the shared data line is pulled low (open-drain) |
| selected_o | output | 1 | Select latch state |
| coef_o | output | 280 | Coefficient bank; entry i occupies bits 8*i+7 down to 8*i |

## Verification
The bench builds the block with its default parameters: 35 entries at address 64, select address 102 with select word 15, and read window at 160. A bank this size can be swept completely. Every entry is written and then read back through the bus. Each address just outside both windows is tried, as is the 16-bit pair write at the top of the bank. Malformed address and data counts, a deselect and reselect sequence, and a long stall inside a transfer are also exercised against a model kept in the bench.

// File: rtl/tcb_pkg.sv
`timescale 1ns/1ps
package tcb_pkg;
  parameter int ADDR_W = 8;
  parameter int BYTE_W = 8;
  parameter int CNT_W  = 5;

  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_DATA, PH_DONE} phase_e;

  // saturating bit counter step
  function automatic logic [CNT_W-1:0] count_step(input logic [CNT_W-1:0] c);
    return (c == '1) ? c : c + CNT_W'(1);
  endfunction

  // true when a lies in [lo, lo+n)
  function automatic logic in_window(input logic [ADDR_W-1:0] a, input int lo, input int n);
    return (int'(a) >= lo) && (int'(a) < lo + n);
  endfunction

  // byte that lands in the addressed entry: after 8 shifts it sits in the upper half
  function automatic logic [BYTE_W-1:0] first_byte(input logic [2*BYTE_W-1:0] sr,
                                                   input logic [CNT_W-1:0] n);
    return (n == CNT_W'(BYTE_W)) ? sr[2*BYTE_W-1:BYTE_W] : sr[BYTE_W-1:0];
  endfunction

  function automatic logic [BYTE_W-1:0] reset_value(input int idx, input int ctl_idx,
                                                    input logic [BYTE_W-1:0] ctl_val);
    return (idx == ctl_idx) ? ctl_val : '0;
  endfunction
endpackage

// File: rtl/tcb_sync.sv
`timescale 1ns/1ps
module tcb_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] sync_o
);
  for (genvar g = 0; g < W; g++) begin : g_line
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b1;
        stab_q <= 1'b1;
      end else begin
        meta_q <= raw_i[g];
        stab_q <= meta_q;
      end
    end
    assign sync_o[g] = stab_q;
  end
endmodule

// File: rtl/tcb_framer.sv
`timescale 1ns/1ps
module tcb_framer
  import tcb_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                id_s,
  input  logic                cl_s,
  input  logic                d_s,
  input  logic                rd_ok,
  input  logic [BYTE_W-1:0]   rd_byte,
  output phase_e              phase,
  output logic [ADDR_W-1:0]   addr_q,
  output logic [2*BYTE_W-1:0] data_q,
  output logic [CNT_W-1:0]    bit_cnt,
  output logic                commit_stb,
  output logic                pull_o
);
  logic id_d, cl_d, rd_act;
  logic [BYTE_W-1:0] out_sr;
  logic id_fall, id_rise, cl_rise;

  assign id_fall = id_d & ~id_s;
  assign id_rise = ~id_d & id_s;
  assign cl_rise = ~cl_d & cl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_d       <= 1'b1;
      cl_d       <= 1'b1;
      phase      <= PH_IDLE;
      addr_q     <= '0;
      data_q     <= '0;
      bit_cnt    <= '0;
      commit_stb <= 1'b0;
      rd_act     <= 1'b0;
      out_sr     <= '1;
    end else begin
      id_d       <= id_s;
      cl_d       <= cl_s;
      commit_stb <= 1'b0;
      case (phase)
        PH_IDLE: if (id_fall) begin
          phase   <= PH_ADDR;
          bit_cnt <= '0;
        end
        PH_ADDR: begin
          if (id_rise) begin
            if (bit_cnt == CNT_W'(ADDR_W)) begin
              phase  <= PH_DATA;
              data_q <= '0;
              rd_act <= rd_ok;
              out_sr <= rd_ok ? rd_byte : '1;
            end else begin
              phase <= PH_IDLE;
            end
            bit_cnt <= '0;
          end else if (cl_rise) begin
            addr_q  <= {d_s, addr_q[ADDR_W-1:1]};
            bit_cnt <= count_step(bit_cnt);
          end
        end
        PH_DATA: begin
          if (id_fall) begin
            commit_stb <= 1'b1;
            rd_act     <= 1'b0;
            phase      <= PH_DONE;
          end else if (cl_rise) begin
            data_q  <= {d_s, data_q[2*BYTE_W-1:1]};
            out_sr  <= {1'b1, out_sr[BYTE_W-1:1]};
            bit_cnt <= count_step(bit_cnt);
          end
        end
        default: if (id_rise) phase <= PH_IDLE;
      endcase
    end
  end

  assign pull_o = rd_act && (phase == PH_DATA) && !out_sr[0];
endmodule

// File: rtl/tcb_coef_bank.sv
`timescale 1ns/1ps
module tcb_coef_bank
  import tcb_pkg::*;
#(
  parameter int              NUM     = 35,
  parameter int              CTL_IDX = 33,
  parameter logic [BYTE_W-1:0] CTL_RST = 8'h08,
  localparam int             IW      = $clog2(NUM)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we0,
  input  logic [IW-1:0]         idx0,
  input  logic [BYTE_W-1:0]     val0,
  input  logic                  we1,
  input  logic [IW-1:0]         idx1,
  input  logic [BYTE_W-1:0]     val1,
  input  logic [IW-1:0]         rd_idx,
  output logic [BYTE_W-1:0]     rd_val,
  output logic [NUM*BYTE_W-1:0] flat_o
);
  logic [BYTE_W-1:0] ent [NUM];

  for (genvar g = 0; g < NUM; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           ent[g] <= reset_value(g, CTL_IDX, CTL_RST);
      else if (we0 && idx0 == IW'(g))       ent[g] <= val0;
      else if (we1 && idx1 == IW'(g))       ent[g] <= val1;
    end
    assign flat_o[g*BYTE_W +: BYTE_W] = ent[g];
  end

  always_comb begin
    rd_val = '1;
    for (int i = 0; i < NUM; i++)
      if (rd_idx == IW'(i)) rd_val = ent[i];
  end
endmodule

// File: rtl/tcb_slave.sv
`timescale 1ns/1ps
module tcb_slave
  import tcb_pkg::*;
#(
  parameter int                COEF_NUM  = 35,
  parameter int                COEF_BASE = 64,
  parameter int                RD_BASE   = 160,
  parameter int                SEL_ADDR  = 102,
  parameter logic [BYTE_W-1:0] SEL_WORD  = 8'd15,
  parameter int                CTL_IDX   = 33,
  parameter logic [BYTE_W-1:0] CTL_RST   = 8'h08
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_ident_i,
  input  logic                       bus_clk_i,
  input  logic                       bus_data_i,
  output logic                       bus_data_pull_o,
  output logic                       selected_o,
  output logic [COEF_NUM*BYTE_W-1:0] coef_o
);
  localparam int IW = $clog2(COEF_NUM);

  logic [2:0] sync_v;
  phase_e phase;
  logic [ADDR_W-1:0] addr_q;
  logic [2*BYTE_W-1:0] data_q;
  logic [CNT_W-1:0] bit_cnt;
  logic commit_stb, selected_q;
  logic map_hit, rd_ok, not_last, sel_hit, we0, we1, len8, len16;
  logic [IW-1:0] wr_idx, rd_idx;
  logic [BYTE_W-1:0] rd_byte;

  tcb_sync #(.W(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .raw_i({bus_ident_i, bus_clk_i, bus_data_i}),
    .sync_o(sync_v)
  );

  tcb_framer u_framer (
    .clk(clk), .rst_n(rst_n),
    .id_s(sync_v[2]), .cl_s(sync_v[1]), .d_s(sync_v[0]),
    .rd_ok(rd_ok), .rd_byte(rd_byte),
    .phase(phase), .addr_q(addr_q), .data_q(data_q), .bit_cnt(bit_cnt),
    .commit_stb(commit_stb), .pull_o(bus_data_pull_o)
  );

  assign len8     = (bit_cnt == CNT_W'(BYTE_W));
  assign len16    = (bit_cnt == CNT_W'(2*BYTE_W));
  assign map_hit  = in_window(addr_q, COEF_BASE, COEF_NUM);
  assign rd_ok    = selected_q && in_window(addr_q, RD_BASE, COEF_NUM);
  assign wr_idx   = IW'(addr_q - ADDR_W'(COEF_BASE));
  assign rd_idx   = IW'(addr_q - ADDR_W'(RD_BASE));
  assign not_last = (wr_idx != IW'(COEF_NUM-1));
  assign sel_hit  = commit_stb && (addr_q == ADDR_W'(SEL_ADDR)) && len8;
  assign we0      = commit_stb && selected_q && map_hit && (len8 || (len16 && not_last));
  assign we1      = commit_stb && selected_q && map_hit && len16 && not_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       selected_q <= 1'b0;
    else if (sel_hit) selected_q <= (data_q[2*BYTE_W-1:BYTE_W] == SEL_WORD);
  end
  assign selected_o = selected_q;

  tcb_coef_bank #(.NUM(COEF_NUM), .CTL_IDX(CTL_IDX), .CTL_RST(CTL_RST)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .we0(we0), .idx0(wr_idx), .val0(first_byte(data_q, bit_cnt)),
    .we1(we1), .idx1(wr_idx + IW'(1)), .val1(data_q[2*BYTE_W-1:BYTE_W]),
    .rd_idx(rd_idx), .rd_val(rd_byte),
    .flat_o(coef_o)
  );
endmodule

// File: rtl/tcb_checker.sv
`timescale 1ns/1ps
module tcb_checker
  import tcb_pkg::*;
#(
  parameter int BANK_W   = 280,
  parameter int SEL_ADDR = 102
) (
  input logic              clk,
  input logic              rst_n,
  input phase_e            phase,
  input logic              commit,
  input logic              pull,
  input logic              selected,
  input logic [ADDR_W-1:0] addr,
  input logic [BANK_W-1:0] bank
);
  // R11: line pulled only inside a data phase
  assert_pull_in_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pull |-> phase == PH_DATA);

  // R3: bank moves only in the cycle after a commit strobe
  assert_bank_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(bank));

  // R3: commit strobe only closes a data phase
  assert_commit_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> phase == PH_DONE);

  // R4: select latch moves only on a commit
  assert_select_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(selected));

  // R7: commits while deselected leave the bank alone
  assert_deselected_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !selected && addr != ADDR_W'(SEL_ADDR)) |=> $stable(bank));
endmodule

bind tcb_slave tcb_checker #(.BANK_W(COEF_NUM*BYTE_W), .SEL_ADDR(SEL_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase), .commit(commit_stb),
  .pull(bus_data_pull_o), .selected(selected_q), .addr(addr_q), .bank(coef_o)
);

// File: tb/tcb_slave_tb.sv
`timescale 1ns/1ps
module tcb_slave_tb;
  localparam int N = 35;
  localparam int H = 8;
  localparam int PAUSE = 3000;

  logic clk = 0, rst_n = 0;
  logic h_id = 1, h_cl = 1, h_d = 1;
  logic pull, sel;
  logic [N*8-1:0] coef;
  logic line;
  int checks = 0, fails = 0;
  logic [7:0] m [N];

  assign line = h_d & ~pull;

  tcb_slave u_dut (
    .clk(clk), .rst_n(rst_n), .bus_ident_i(h_id), .bus_clk_i(h_cl),
    .bus_data_i(line), .bus_data_pull_o(pull), .selected_o(sel), .coef_o(coef)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_bank(input string tag);
    int bad = -1;
    checks++;
    for (int i = 0; i < N; i++)
      if (bad < 0 && coef[i*8 +: 8] !== m[i]) bad = i;
    if (bad >= 0) begin
      fails++;
      $display("FAIL %s entry %0d actual=%0h expected=%0h", tag, bad, coef[bad*8 +: 8], m[bad]);
    end
  endtask

  task automatic gap();
    repeat (H) @(negedge clk);
  endtask

  task automatic commit_pulse();
    h_id = 0; gap(); h_id = 1; gap(); gap();
  endtask

  task automatic xfer(input int abits, input logic [7:0] a, input int dbits,
                      input logic [15:0] v, input bit do_commit, input int pause_at,
                      output logic [15:0] rd);
    rd = '1;
    @(negedge clk); h_id = 0; gap();
    for (int k = 0; k < abits; k++) begin
      h_cl = 0; h_d = a[k % 8]; gap(); h_cl = 1; gap();
    end
    h_id = 1; h_d = 1; gap();
    for (int k = 0; k < dbits; k++) begin
      if (k == pause_at) repeat (PAUSE) @(negedge clk);
      h_cl = 0; h_d = v[k]; gap();
      rd[k] = line;
      h_cl = 1; gap();
    end
    h_d = 1;
    if (do_commit) commit_pulse();
  endtask

  task automatic wr8(input logic [7:0] a, input logic [7:0] v);
    logic [15:0] r;
    xfer(8, a, 8, {8'h00, v}, 1, -1, r);
  endtask

  task automatic rd8(input logic [7:0] a, output logic [7:0] v);
    logic [15:0] r;
    xfer(8, a, 8, 16'hFFFF, 1, -1, r);
    v = r[7:0];
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [7:0] rv;
    logic [15:0] r16;
    for (int i = 0; i < N; i++) m[i] = (i == 33) ? 8'h08 : 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // R1 reset state
    check_bank("R1 reset bank");
    chk("R1 reset deselected", 32'(sel), 0);
    chk("R1 reset line released", 32'(pull), 0);

    // R7 / R9 while deselected
    wr8(8'd64, 8'h55);
    check_bank("R7 deselected write ignored");
    rd8(8'd160, rv);
    chk("R9 deselected read", 32'(rv), 32'hFF);

    // R4 select
    wr8(8'd102, 8'd15);
    chk("R4 select word", 32'(sel), 1);

    // R5 full sweep
    for (int i = 0; i < N; i++) begin
      wr8(8'(64 + i), pat(i));
      m[i] = pat(i);
    end
    check_bank("R5 sweep write");

    // R8 read back every entry
    for (int i = 0; i < N; i++) begin
      rd8(8'(160 + i), rv);
      chk($sformatf("R8 read entry %0d", i), 32'(rv), 32'(m[i]));
    end

    // R7 out-of-map addresses
    foreach (m[i]) ;
    begin
      logic [7:0] bad_a [7] = '{8'd63, 8'd99, 8'd100, 8'd101, 8'd103, 8'd0, 8'd255};
      for (int k = 0; k < 7; k++) begin
        wr8(bad_a[k], 8'hAA);
        check_bank($sformatf("R7 out-of-map %0d", bad_a[k]));
      end
    end

    // R7 bad data count
    xfer(8, 8'd64, 12, 16'h0FA5, 1, -1, r16);
    check_bank("R7 12-bit data ignored");

    // R2 malformed address counts
    xfer(7, 8'd65, 8, 16'h00C3, 1, -1, r16);
    check_bank("R2 7-bit address ignored");
    xfer(9, 8'd65, 8, 16'h00C3, 1, -1, r16);
    check_bank("R2 9-bit address ignored");

    // R3 no change before the ident pulse
    xfer(8, 8'd66, 8, 16'h005A, 0, -1, r16);
    repeat (20) @(negedge clk);
    check_bank("R3 before commit pulse");
    commit_pulse();
    m[2] = 8'h5A;
    check_bank("R3 after commit pulse");

    // R6 16-bit pair write
    xfer(8, 8'd70, 16, 16'hBEEF, 1, -1, r16);
    m[6] = 8'hEF; m[7] = 8'hBE;
    check_bank("R6 pair write");
    xfer(8, 8'd98, 16, 16'h1234, 1, -1, r16);
    check_bank("R6 pair at last entry ignored");

    // R9 reads outside the window
    rd8(8'd195, rv);
    chk("R9 read 195", 32'(rv), 32'hFF);
    rd8(8'd159, rv);
    chk("R9 read 159", 32'(rv), 32'hFF);

    // R10 long pause inside data bits
    xfer(8, 8'd65, 8, 16'h0077, 1, 4, r16);
    m[1] = 8'h77;
    check_bank("R10 paused write");

    // R4 deselect then reselect
    wr8(8'd102, 8'd14);
    chk("R4 deselect", 32'(sel), 0);
    wr8(8'd64, 8'h99);
    check_bank("R4 write after deselect ignored");
    wr8(8'd102, 8'd15);
    wr8(8'd64, 8'h99);
    m[0] = 8'h99;
    check_bank("R4 write after reselect");
    rd8(8'd160, rv);
    chk("R8 read after reselect", 32'(rv), 32'h99);
    chk("R11 line released at idle", 32'(pull), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule